// File: doc/BRIEF.md
# Per-Pin External Interrupt Detector

This block detects external interrupt events for a 32-pin port. Each pin is first brought into the clock domain through a synchronizer. A 4-bit trigger field for each pin selects the event that is detected on the synchronized level. The choices are rising edge, falling edge, both edges, high level or low level.

Detected events latch into a per-pin pending register. Software clears a pending bit by writing a one to that bit. A per-pin enable mask selects which pending bits drive a single registered interrupt line. A debounce word is held for software and reads back unchanged. The block does not use the debounce word for detection.

Software reaches the registers through a simple word-indexed write and read port. A write takes effect on the clock edge. A read returns the register at the current index combinationally.

Top module: `gpio_eint_det`

## Requirements
- R1: Pin n's 4-bit trigger field sits in configuration word n>>3 (word indices 0 to 3, byte offsets 0x00 to 0x0C), at bits (n&7)*4+3 down to (n&7)*4. The words read back as written.
- R2: Trigger code 0 sets pin n's pending bit when the synchronized pin goes from 0 to 1. A pin change made before edge k is first visible in the pending bit after edge k+2.
- R3: Trigger code 1 sets the pending bit on a 1-to-0 transition of the synchronized pin, and not on a 0-to-1 transition.
- R4: Trigger code 2 sets the pending bit on every cycle in which the synchronized pin is 1. Code 3 does the same when the pin is 0. A clear therefore does not stick while the level persists.
- R5: Trigger code 4 sets the pending bit on both rising and falling transitions.
- R6: Trigger codes 5 to 15 never set the pending bit of that pin.
- R7: The pending register is at word index 5 (byte 0x14). Writing 1 to bit n clears pending bit n, and writing 0 leaves it unchanged. An event in the same cycle as the clear keeps the bit set.
- R8: The enable register is at word index 4 (byte 0x10). The interrupt output is high in the cycle after any bit is set in both the pending and the enable registers, and low otherwise.
- R9: Pending bits are set whether or not the pin's enable bit is 1.
- R10: The debounce word is at word index 6 (byte 0x18) and reads back as written. Index 7 reads zero.
- R11: After reset, all registers read zero and the interrupt output is low. With every field at code 0, all pins use rising-edge detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Raw pin levels from the pads |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word index (byte offset / 4) |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for the register at addr_i |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The assertions assume that the write strobe, index and data are stable around each rising edge. They also assume that the pins are quiet during reset, so that no event arrives before the first clear. The bench changes every input only on falling edges and holds the pins low through reset. It then mixes directed trigger cases with a random phase of pin toggles and register writes. In that phase the clears can land in the same cycle as fresh events.

// File: rtl/gpio_eint_pkg.sv
package gpio_eint_pkg;
    localparam int DATA_W  = 32;
    localparam int FIELD_W = 4;

    typedef enum logic [FIELD_W-1:0] {
        TRIG_RISE = 4'd0,
        TRIG_FALL = 4'd1,
        TRIG_HIGH = 4'd2,
        TRIG_LOW  = 4'd3,
        TRIG_BOTH = 4'd4
    } trig_e;

    localparam logic [2:0] IDX_ENABLE   = 3'd4;
    localparam logic [2:0] IDX_STATUS   = 3'd5;
    localparam logic [2:0] IDX_DEBOUNCE = 3'd6;
endpackage

// File: rtl/gpio_eint_sync.sv
module gpio_eint_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_eint_trig.sv
module gpio_eint_trig
    import gpio_eint_pkg::*;
(
    input  logic               cur_i,
    input  logic               prev_i,
    input  logic [FIELD_W-1:0] code_i,
    output logic               hit_o
);
    always_comb begin
        unique case (code_i)
            TRIG_RISE: hit_o = cur_i & ~prev_i;
            TRIG_FALL: hit_o = ~cur_i & prev_i;
            TRIG_HIGH: hit_o = cur_i;
            TRIG_LOW:  hit_o = ~cur_i;
            TRIG_BOTH: hit_o = cur_i ^ prev_i;
            default:   hit_o = 1'b0;
        endcase
    end

    always_comb begin
        if (code_i > 4'd4) begin
            AST_UNUSED_CODE_QUIET: assert (!hit_o); // R6
        end
    end
endmodule

// File: rtl/gpio_eint_det.sv
module gpio_eint_det
    import gpio_eint_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int CFG_BITS  = NPINS * FIELD_W;
    localparam int CFG_WORDS = CFG_BITS / DATA_W;

    typedef struct packed {
        logic [CFG_BITS-1:0] cfg;
        logic [NPINS-1:0]    en;
        logic [NPINS-1:0]    pend;
        logic [DATA_W-1:0]   deb;
        logic [NPINS-1:0]    prev;
        logic                irq;
    } state_t;

    state_t            st_d, st_q;
    logic [NPINS-1:0]  pin_s;
    logic [NPINS-1:0]  ev;
    logic [NPINS-1:0]  clr;
    logic              wr_status;

    gpio_eint_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_eint_trig u_trig (
            .cur_i  (pin_s[i]),
            .prev_i (st_q.prev[i]),
            .code_i (st_q.cfg[i*FIELD_W +: FIELD_W]),
            .hit_o  (ev[i])
        );
    end

    assign wr_status = wr_en_i && (addr_i == IDX_STATUS);

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_s;
        clr       = wr_status ? wdata_i[NPINS-1:0] : '0;
        for (int w = 0; w < CFG_WORDS; w++) begin
            if (wr_en_i && addr_i == ADDR_W'(w))
                st_d.cfg[w*DATA_W +: DATA_W] = wdata_i;
        end
        if (wr_en_i && addr_i == IDX_ENABLE)   st_d.en  = wdata_i[NPINS-1:0];
        if (wr_en_i && addr_i == IDX_DEBOUNCE) st_d.deb = wdata_i;
        st_d.pend = (st_q.pend & ~clr) | ev;
        st_d.irq  = |(st_q.pend & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        for (int w = 0; w < CFG_WORDS; w++) begin
            if (addr_i == ADDR_W'(w)) rdata_o = st_q.cfg[w*DATA_W +: DATA_W];
        end
        if (addr_i == IDX_ENABLE)   rdata_o = DATA_W'(st_q.en);
        if (addr_i == IDX_STATUS)   rdata_o = DATA_W'(st_q.pend);
        if (addr_i == IDX_DEBOUNCE) rdata_o = st_q.deb;
    end

    assign irq_o = st_q.irq;

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> ((st_q.pend & $past(wdata_i[NPINS-1:0] & ~ev)) == '0)); // R7
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((st_q.pend & $past(ev)) == $past(ev))); // R7
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_status |=> ((~st_q.pend & $past(st_q.pend)) == '0)); // R7
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((st_q.pend & st_q.en) != '0)); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.pend & st_q.en) == '0) |=> !irq_o); // R8
endmodule

// File: tb/gpio_eint_det_bench.sv
`timescale 1ns/1ps
module gpio_eint_det_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_i = '0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  addr_i = 3'd5;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    gpio_eint_det u_gpio_eint_det (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    // behavioural reference state
    bit [31:0] m_s1, m_s2, m_prv, m_pend, m_en, m_deb;
    bit [31:0] m_cfg [4];
    bit        m_irq;

    function automatic bit fires(int code, bit cur, bit prv);
        case (code)
            0: return cur && !prv;
            1: return !cur && prv;
            2: return cur;
            3: return !cur;
            4: return cur != prv;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit [31:0] m_read(int a);
        if (a < 4) return m_cfg[a];
        if (a == 4) return m_en;
        if (a == 5) return m_pend;
        if (a == 6) return m_deb;
        return 32'h0;
    endfunction

    task automatic check(string tag, bit [31:0] act, bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit [31:0] ev, clr;
        bit        nirq;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prv = 0; m_pend = 0; m_en = 0; m_deb = 0; m_irq = 0;
            for (int k = 0; k < 4; k++) m_cfg[k] = 0;
        end else begin
            for (int n = 0; n < 32; n++)
                ev[n] = fires(int'((m_cfg[n/8] >> ((n%8)*4)) & 4'hF), m_s2[n], m_prv[n]);
            nirq = (m_pend & m_en) != 0;
            clr = (wr_en_i && addr_i == 3'd5) ? wdata_i : 32'h0;
            m_pend = (m_pend & ~clr) | ev;
            if (wr_en_i && addr_i < 3'd4) m_cfg[addr_i] = wdata_i;
            if (wr_en_i && addr_i == 3'd4) m_en = wdata_i;
            if (wr_en_i && addr_i == 3'd6) m_deb = wdata_i;
            m_prv = m_s2; m_s2 = m_s1; m_s1 = pin_i; m_irq = nirq;
        end
        #1;
        check("R8 irq per-cycle", {31'b0, irq_o}, {31'b0, m_irq});
        if (addr_i < 3'd4)       check("R1 cfg per-cycle", rdata_o, m_read(addr_i));
        else if (addr_i == 3'd4) check("R8 enable per-cycle", rdata_o, m_read(addr_i));
        else if (addr_i == 3'd5) check("R7 status per-cycle", rdata_o, m_read(addr_i));
        else                     check("R10 debounce per-cycle", rdata_o, m_read(addr_i));
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; addr_i = 3'd5; wdata_i = '0;
    endtask

    task automatic bitchk(string tag, int b, bit exp);
        addr_i = 3'd5;
        #0.1;
        check(tag, {31'b0, rdata_o[b]}, {31'b0, exp});
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit [31:0] snap;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check("R11 status after reset", rdata_o, 32'h0);
        check("R11 irq after reset", {31'b0, irq_o}, 32'h0);

        // pin0 rise, pin1 fall, pin2 high, pin3 low, pin4 both, pin5 unused code 7
        wr(3'd0, 32'h0074_3210);
        tick(1);
        wr(3'd5, 32'hFFFF_FFFF);
        pin_i[0] = 1'b1; pin_i[2] = 1'b1; pin_i[5] = 1'b1;
        tick(4);
        bitchk("R2 rising sets pending", 0, 1'b1);
        bitchk("R4 high level pending", 2, 1'b1);
        bitchk("R4 low level pending", 3, 1'b1);
        bitchk("R6 unused code quiet", 5, 1'b0);
        check("R9 pending without enable, irq low", {31'b0, irq_o}, 32'h0);

        wr(3'd5, 32'h1);
        bitchk("R7 write-one clears", 0, 1'b0);
        wr(3'd5, 32'h4);
        tick(1);
        bitchk("R4 R7 level re-sets after clear", 2, 1'b1);
        snap = rdata_o;
        wr(3'd5, 32'h0);
        addr_i = 3'd5; #0.1;
        check("R7 write zero no effect", rdata_o & 32'h13, snap & 32'h13);

        pin_i[1] = 1'b1;
        tick(4);
        bitchk("R3 no event on rise", 1, 1'b0);
        pin_i[1] = 1'b0;
        tick(4);
        bitchk("R3 falling sets pending", 1, 1'b1);

        pin_i[4] = 1'b1;
        tick(4);
        bitchk("R5 both: rise", 4, 1'b1);
        wr(3'd5, 32'h10);
        bitchk("R5 cleared", 4, 1'b0);
        pin_i[4] = 1'b0;
        tick(4);
        bitchk("R5 both: fall", 4, 1'b1);

        wr(3'd4, 32'h10);
        tick(2);
        check("R8 irq with enabled pending", {31'b0, irq_o}, 32'h1);
        wr(3'd5, 32'h10);
        tick(2);
        check("R8 irq drops after clear", {31'b0, irq_o}, 32'h0);

        wr(3'd6, 32'hA5A5_0003);
        addr_i = 3'd6; #0.1;
        check("R10 debounce readback", rdata_o, 32'hA5A5_0003);
        addr_i = 3'd7; #0.1;
        check("R10 unused index reads zero", rdata_o, 32'h0);

        wr(3'd3, 32'h4000_0000);
        addr_i = 3'd3; #0.1;
        check("R1 cfg word 3 readback", rdata_o, 32'h4000_0000);
        pin_i[31] = 1'b1;
        tick(4);
        bitchk("R1 pin31 field at top of word 3", 31, 1'b1);

        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            pin_i = $urandom;
            wr_en_i = ($urandom % 3) == 0;
            addr_i = 3'($urandom % 8);
            wdata_i = $urandom;
        end
        @(negedge clk);
        wr_en_i = 1'b0;
        tick(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule